// File: doc/BRIEF.md
# Way-Halting Four-Way Cache Lookup

This block is the lookup and fill core of a four-way set-associative cache that saves array energy by halting ways early. Beside the full tag and data arrays of each way it keeps a small register store holding, for every line, its valid bit and the four least significant bits of its tag. In the cycle a request arrives, that store is read at the request's set index and compared with the request's low tag bits. Only ways that are valid and agree on those four bits get their tag and data arrays enabled. Every other way stays idle for the whole access.

The filter runs in the same cycle as index decode, so it adds no latency. A response comes back one cycle after the request. Its hit, hit way and line value are exactly what a plain four-way cache of the same shape would give, because a halted way can never hold the requested tag.

A refill port writes a new line into the victim way. The victim is picked round-robin, with a separate pointer for each set, and the block shows the chosen way on an output. The per-way enable vector is brought out so that array activity can be counted.

Top module: `wh_cache_lookup`

## Requirements
- R1: After synchronous reset every line is invalid, so no request hits or enables any way. Every set's victim pointer starts at way 0.
- R2: An address splits into a byte offset in bits [3:0], a set index in bits [9:4] and a tag in bits [31:10]. The halt field is tag bits [3:0], which are address bits [13:10].
- R3: In the cycle of a request, `way_en[w]` is high exactly when `req_valid` is high, line w of the indexed set is valid, and its stored halt field equals the request's halt field. With no request, `way_en` is all zero.
- R4: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low otherwise. Requests may be issued on back-to-back cycles.
- R5: A response hits exactly when some valid way of the indexed set holds the full request tag. Then `rsp_way` is that way and `rsp_line` is its stored line. On a miss `rsp_hit`, `rsp_way` and `rsp_line` are all zero.
- R6: A valid way whose halt field matches but whose upper tag differs is enabled but does not hit.
- R7: A refill (`fill_valid` high) writes tag, halt field, valid bit and line into the way shown on `fill_way` in one cycle. A request in a later cycle sees the new line.
- R8: `fill_way` shows the victim pointer of the set addressed by `fill_addr`. Each refill moves that set's pointer on by one (0, 1, 2, 3, 0, ...) and leaves all other sets' pointers unchanged.
- R9: Even when several ways of one set share the same halt field, at most one way hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Lookup byte address |
| fill_valid | input | 1 | Refill write strobe |
| fill_addr | input | 32 | Refill byte address |
| fill_line | input | 128 | Refill line contents |
| fill_way | output | 2 | Victim way for the set of `fill_addr` |
| way_en | output | 4 | Per-way tag and data array enable for the current request |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Response hit |
| rsp_way | output | 2 | Way that hit |
| rsp_line | output | 128 | Line read from the hitting way |

## Verification
The assertions check on every cycle the properties that need no memory of stored contents. Enables are silent without a request. A response follows each request by exactly one cycle. No more than one way hits. A reported hit way must have been enabled the cycle before. A miss returns zeros. Only the bench's scenarios can show that the enable vector equals the expected halt filter, that hits and lines agree with a plain four-way reference model, that a false alias on the low tag bits still misses, and that the victim pointers rotate per set.

// File: rtl/wh_pkg.sv
package wh_pkg;
    parameter int ADDR_W     = 32;
    parameter int LINE_BYTES = 16;
    parameter int SETS       = 64;
    parameter int WAYS       = 4;
    parameter int HALT_W     = 4;

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LINE_W = LINE_BYTES * 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [HALT_W-1:0] halt_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [WAYS-1:0]   wvec_t;

    // Request fields as seen by the lookup path
    typedef struct packed {
        tag_t  tag;
        idx_t  idx;
        halt_t halt;
    } lookup_t;

    function automatic idx_t idx_of(addr_t a);
        return a[OFF_W +: IDX_W];
    endfunction

    function automatic tag_t tag_of(addr_t a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic halt_t halt_of(tag_t t);
        return t[HALT_W-1:0];
    endfunction

    function automatic lookup_t decode(addr_t a);
        lookup_t r;
        r.tag  = tag_of(a);
        r.idx  = idx_of(a);
        r.halt = halt_of(r.tag);
        return r;
    endfunction
endpackage

// File: rtl/wh_halt_store.sv
module wh_halt_store
    import wh_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  lk_req,
    input  idx_t  lk_idx,
    input  halt_t lk_halt,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  way_t  wr_way,
    input  halt_t wr_halt,
    output wvec_t way_en
);
    wvec_t vld   [SETS];
    halt_t hbits [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld[s] <= '0;
            end
        end else if (wr_en) begin
            vld[wr_idx][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            hbits[wr_idx][wr_way] <= wr_halt;
        end
    end

    // Static compare, evaluated alongside the set decode of the request
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        always_comb begin
            way_en[w] = lk_req && vld[lk_idx][w] && (hbits[lk_idx][w] == lk_halt);
        end
    end
endmodule

// File: rtl/wh_victim_rr.sv
module wh_victim_rr
    import wh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t set_idx,
    input  logic advance,
    output way_t victim
);
    way_t ptr [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                ptr[s] <= '0;
            end
        end else if (advance) begin
            ptr[set_idx] <= ptr[set_idx] + way_t'(1);
        end
    end

    assign victim = ptr[set_idx];
endmodule

// File: rtl/wh_way_array.sv
module wh_way_array
    import wh_pkg::*;
(
    input  logic  clk,
    input  logic  rd_en,
    input  idx_t  rd_idx,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  tag_t  wr_tag,
    input  line_t wr_line,
    output tag_t  rd_tag,
    output line_t rd_line
);
    tag_t  tag_mem  [SETS];
    line_t data_mem [SETS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_line;
        end
    end

    // Arrays are only clocked for a read when the halt filter lets them
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_tag  <= tag_mem[rd_idx];
            rd_line <= data_mem[rd_idx];
        end
    end
endmodule

// File: rtl/wh_cache_lookup.sv
module wh_cache_lookup
    import wh_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                fill_valid,
    input  logic [ADDR_W-1:0]   fill_addr,
    input  logic [LINE_W-1:0]   fill_line,
    output logic [WAY_W-1:0]    fill_way,
    output logic [WAYS-1:0]     way_en,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [WAY_W-1:0]    rsp_way,
    output logic [LINE_W-1:0]   rsp_line
);
    lookup_t lk;
    lookup_t fl;
    tag_t    tag_q;
    wvec_t   en_q;
    wvec_t   hit_vec;
    tag_t    rd_tag  [WAYS];
    line_t   rd_line [WAYS];

    assign lk = decode(req_addr);
    assign fl = decode(fill_addr);

    wh_halt_store u_halt (
        .clk     (clk),
        .rst     (rst),
        .lk_req  (req_valid),
        .lk_idx  (lk.idx),
        .lk_halt (lk.halt),
        .wr_en   (fill_valid),
        .wr_idx  (fl.idx),
        .wr_way  (fill_way),
        .wr_halt (fl.halt),
        .way_en  (way_en)
    );

    wh_victim_rr u_rr (
        .clk     (clk),
        .rst     (rst),
        .set_idx (fl.idx),
        .advance (fill_valid),
        .victim  (fill_way)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        wh_way_array u_arr (
            .clk     (clk),
            .rd_en   (way_en[w]),
            .rd_idx  (lk.idx),
            .wr_en   (fill_valid && (fill_way == way_t'(w))),
            .wr_idx  (fl.idx),
            .wr_tag  (fl.tag),
            .wr_line (fill_line),
            .rd_tag  (rd_tag[w]),
            .rd_line (rd_line[w])
        );

        always_comb begin
            hit_vec[w] = en_q[w] && (rd_tag[w] == tag_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            en_q      <= '0;
            tag_q     <= '0;
        end else begin
            rsp_valid <= req_valid;
            en_q      <= way_en;
            tag_q     <= lk.tag;
        end
    end

    always_comb begin
        rsp_hit  = |hit_vec;
        rsp_way  = '0;
        rsp_line = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                rsp_way  = way_t'(w);
                rsp_line = rd_line[w];
            end
        end
    end
endmodule

// File: rtl/wh_cache_lookup_chk.sv
module wh_cache_lookup_chk
    import wh_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  req_valid,
    input wvec_t way_en,
    input logic  rsp_valid,
    input logic  rsp_hit,
    input way_t  rsp_way,
    input line_t rsp_line,
    input wvec_t hit_vec
);
    wvec_t en_d;

    always_ff @(posedge clk) begin
        if (rst) en_d <= '0;
        else     en_d <= way_en;
    end

    p_no_req_no_en_r3: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (way_en == '0));

    p_rsp_follows_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_rsp_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_single_hit_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    p_hit_was_enabled_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> en_d[rsp_way]);

    p_hit_has_rsp_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    p_miss_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_line == '0 && rsp_way == '0));
endmodule

bind wh_cache_lookup wh_cache_lookup_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .way_en    (way_en),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_way   (rsp_way),
    .rsp_line  (rsp_line),
    .hit_vec   (hit_vec)
);

// File: tb/wh_cache_lookup_tb.sv
`timescale 1ns/1ps
module wh_cache_lookup_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic [31:0]  req_addr;
    logic         fill_valid;
    logic [31:0]  fill_addr;
    logic [127:0] fill_line;
    logic [1:0]   fill_way;
    logic [3:0]   way_en;
    logic         rsp_valid;
    logic         rsp_hit;
    logic [1:0]   rsp_way;
    logic [127:0] rsp_line;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model of a plain four-way cache
    logic [21:0]  m_tag  [64][4];
    bit           m_vld  [64][4];
    logic [127:0] m_line [64][4];
    int           m_rr   [64];

    always #5 clk = ~clk;

    wh_cache_lookup u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_line(fill_line),
        .fill_way(fill_way), .way_en(way_en), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_line(rsp_line)
    );

    function automatic logic [31:0] mk(logic [21:0] t, logic [5:0] s);
        return {t, s, 4'h0};
    endfunction

    function automatic logic [127:0] pat(logic [31:0] a);
        return {a, ~a, a ^ 32'h5A5A_C3C3, a + 32'h1111};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_en(logic [31:0] a);
        logic [3:0] e;
        for (int w = 0; w < 4; w++)
            e[w] = m_vld[a[9:4]][w] && (m_tag[a[9:4]][w][3:0] == a[13:10]);
        return e;
    endfunction

    task automatic fill(input logic [31:0] a, input string req);
        int s;
        s = int'(a[9:4]);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = a;
        fill_line  = pat(a);
        #1;
        chk(fill_way == 2'(m_rr[s]), req, 128'(fill_way), 128'(m_rr[s]));
        @(negedge clk);
        fill_valid = 1'b0;
        m_tag[s][m_rr[s]]  = a[31:10];
        m_vld[s][m_rr[s]]  = 1'b1;
        m_line[s][m_rr[s]] = pat(a);
        m_rr[s] = (m_rr[s] + 1) % 4;
    endtask

    // Issues n back-to-back requests, checking enables in-cycle and responses one cycle later
    task automatic burst(input logic [31:0] a [4], input int n, input string req);
        bit           ph, eh;
        logic [1:0]   ew;
        logic [127:0] el;
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk(rsp_valid == 1'b1, {req, " R4 rsp_valid"}, 128'(rsp_valid), 128'(1));
                chk(rsp_hit == eh, {req, " R5 hit"}, 128'(rsp_hit), 128'(eh));
                chk(rsp_way == ew, {req, " R5 way"}, 128'(rsp_way), 128'(ew));
                chk(rsp_line == el, {req, " R5 line"}, rsp_line, el);
            end
            if (i < n) begin
                req_valid = 1'b1;
                req_addr  = a[i];
                eh = 1'b0; ew = 2'd0; el = '0;
                for (int w = 0; w < 4; w++) begin
                    if (m_vld[a[i][9:4]][w] && m_tag[a[i][9:4]][w] == a[i][31:10]) begin
                        eh = 1'b1; ew = 2'(w); el = m_line[a[i][9:4]][w];
                    end
                end
                #1;
                chk(way_en == exp_en(a[i]), {req, " R3 way_en"}, 128'(way_en), 128'(exp_en(a[i])));
            end else begin
                req_valid = 1'b0;
            end
            ph = eh;
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0 && rsp_hit == 1'b0, {req, " R4 idle"}, 128'({rsp_valid, rsp_hit}), 128'(0));
    endtask

    task automatic one(input logic [31:0] x, input string req);
        logic [31:0] a [4];
        a[0] = x; a[1] = '0; a[2] = '0; a[3] = '0;
        burst(a, 1, req);
    endtask

    task automatic t_reset;
        rst = 1'b1; req_valid = 1'b0; req_addr = '0;
        fill_valid = 1'b0; fill_addr = '0; fill_line = '0;
        for (int s = 0; s < 64; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < 4; w++) begin
                m_vld[s][w] = 1'b0; m_tag[s][w] = '0; m_line[s][w] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 128'(rsp_valid), 128'(0));
        chk(way_en == 4'b0, "R1 way_en after reset", 128'(way_en), 128'(0));
        chk(fill_way == 2'd0, "R1 victim pointer after reset", 128'(fill_way), 128'(0));
        one(mk(22'h0, 6'd0), "R1 invalid lines never enable");
    endtask

    task automatic t_fill_set;
        fill(mk(22'h000A1, 6'd5), "R8 victim way0");
        fill(mk(22'h12342, 6'd5), "R8 victim way1");
        fill(mk(22'h3FF03, 6'd5), "R8 victim way2");
        fill(mk(22'h00404, 6'd5), "R8 victim way3");
        one(mk(22'h000A1, 6'd5) | 32'h0000_000C, "R7 R2 hit way0 any offset");
        one(mk(22'h12342, 6'd5), "R7 hit way1");
        one(mk(22'h3FF03, 6'd5), "R7 hit way2");
        one(mk(22'h00404, 6'd5), "R7 hit way3");
        one(mk(22'h00009, 6'd5), "R3 all ways halted");
    endtask

    task automatic t_alias;
        one(mk(22'h00011, 6'd5), "R6 halt alias misses");
        one(mk(22'h000A1, 6'd6), "R2 other set misses");
    endtask

    task automatic t_wrap;
        fill(mk(22'h00055, 6'd5), "R8 pointer wraps to way0");
        one(mk(22'h000A1, 6'd5), "R8 replaced line misses");
        one(mk(22'h00055, 6'd5), "R7 new line hits way0");
        fill(mk(22'h00100, 6'd9), "R8 other set starts at way0");
    endtask

    task automatic t_shared_halt;
        fill(mk(22'h10007, 6'd20), "R8 set20 way0");
        fill(mk(22'h00007, 6'd20), "R8 set20 way1");
        fill(mk(22'h2A007, 6'd20), "R8 set20 way2");
        one(mk(22'h00007, 6'd20), "R9 shared halt single hit");
        one(mk(22'h3C007, 6'd20), "R6 shared halt three enabled miss");
    endtask

    task automatic t_edges;
        logic [31:0] a [4];
        fill(mk(22'h3FFFFF, 6'd63), "R2 top set fill");
        fill(mk(22'h000000, 6'd0),  "R2 bottom set fill");
        a[0] = mk(22'h3FFFFF, 6'd63) | 32'hF;
        a[1] = mk(22'h000000, 6'd0);
        a[2] = mk(22'h12342, 6'd5);
        a[3] = mk(22'h3FFFFE, 6'd63);
        burst(a, 4, "R4 back-to-back");
    endtask

    initial begin
        t_reset();
        t_fill_set();
        t_alias();
        t_wrap();
        t_shared_halt();
        t_edges();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule